// File: doc/BRIEF.md
# Transmit Error Statistics Counters

This block keeps the transmit-side error statistics of an Ethernet MAC, in the manner of a network management counter set. When the transmit engine finishes a frame attempt, it pulses a completion strobe together with a vector of status flags. The block steps every counter whose cause is flagged for that frame. The causes are:

- the collision limit was reached,
- the deferral timeout expired,
- a late (out-of-window) collision occurred,
- the carrier was missing or dropped,
- the collision heartbeat was absent,
- the transmit FIFO ran dry,
- software aborted the frame.

Software reads the counters through a small register-read port. A read can optionally clear the counter it reads. All counters saturate rather than wrap.

The block also holds the excessive-deferral timer. The timer counts core clock cycles for as long as the transmitter reports that it is deferring. When the run reaches the configured limit (400000 cycles by default, which is 3.2 ms at 125 MHz), the timer raises a one-cycle abort request towards the transmit engine.

Top module: `tx_err_stats`

## Requirements
- R1: After reset, every counter reads as zero and the deferral abort output is low.
- R2: The status flag bits are: bit 0 collision limit, bit 1 deferral timeout, bit 2 late collision, bit 3 carrier error, bit 4 missing heartbeat, bit 5 FIFO underrun, bit 6 manual abort. The counter addresses are: 1 collision limit, 2 deferral timeout, 3 late collision, 4 carrier error, 5 missing heartbeat. A strobe with bit k set (k = 0 to 4) adds one to the counter at address k+1.
- R3: The errored-frame counter at address 0 adds one for a strobe that carries any of bits 0, 1, 2, 5 or 6. It does not count a strobe that carries only bits 3 and/or 4, nor one with no flags set.
- R4: When a strobe carries several flags, each affected counter adds exactly one for that frame.
- R5: Flags presented while the completion strobe is low change no counter.
- R6: A counter that holds all ones stays at all ones on further increments.
- R7: A read strobe returns the addressed counter on the data output one cycle later, and the data output holds that value until the next read. A read without clear leaves the counter unchanged. Addresses 6 and 7 read as zero.
- R8: A read with clear set zeroes the addressed counter. If an increment for that counter arrives in the same cycle, the counter becomes 1. The read still returns the value the counter held before the clear.
- R9: The deferral abort output is high for exactly one cycle: the DEFER_LIMIT-th consecutive cycle in which the deferring input is high. A shorter run raises nothing, and the count restarts whenever deferring goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Frame completion strobe |
| stat_i | input | 7 | Per-frame status flags (bit layout in R2) |
| deferring_i | input | 1 | Transmitter is currently deferring |
| defer_abort_o | output | 1 | Deferral timeout abort request |
| rd_i | input | 1 | Read strobe |
| rd_clr_i | input | 1 | Clear the addressed counter on this read |
| rd_addr_i | input | 3 | Counter address |
| rd_data_o | output | CNT_W | Read data, valid the cycle after rd_i |

## Verification
Assertions check the per-counter rules on every cycle:

- saturation holds at all ones,
- a clear yields 0, or 1 when an increment coincides,
- a counter never moves by more than one per cycle,
- the errored counter stays still without a strobe or a clear,
- the deferral abort is a lone pulse that only occurs while the transmitter is deferring.

The bench scenarios are what show that the flag-to-counter mapping and the errored-frame selection are correct. It sweeps all 128 flag patterns, with the counters narrowed to 4 bits so that saturation is reachable. The scenarios also cover read latency, clear-with-increment collisions and the exact cycle of the deferral abort.

// File: rtl/tx_stats_pkg.sv
package tx_stats_pkg;
  localparam int unsigned N_FLAG = 7;
  localparam int unsigned N_CNT  = 6;
  localparam int unsigned AW     = 3;

  // flag bit positions on stat_i
  localparam int unsigned F_COLL_LIM = 0;
  localparam int unsigned F_DEF_TO   = 1;
  localparam int unsigned F_LATE     = 2;
  localparam int unsigned F_CARRIER  = 3;
  localparam int unsigned F_NO_HB    = 4;
  localparam int unsigned F_UNDERRUN = 5;
  localparam int unsigned F_SW_ABORT = 6;

  // flags that mark a frame as errored
  localparam logic [N_FLAG-1:0] ERR_MASK = 7'b110_0111;

  typedef logic [N_FLAG-1:0] tx_flags_t;

  // counter increment vector from one completion
  function automatic logic [N_CNT-1:0] flag_to_inc(input logic done, input tx_flags_t f);
    logic [N_CNT-1:0] inc;
    inc[0] = done & |(f & ERR_MASK);
    for (int k = 1; k < N_CNT; k++) inc[k] = done & f[k-1];
    return inc;
  endfunction
endpackage

// File: rtl/tx_sat_counter.sv
module tx_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= inc_i ? ONE : '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);
  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> cnt_q == '0);
  a_r8_clear_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> cnt_q == ONE);
  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
  parameter int unsigned LIMIT = 400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic deferring_i,
  output logic abort_o
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);
  localparam logic [TW-1:0] FULL = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  // holds at FULL after expiry so the abort fires once per deferral run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!deferring_i)   cnt_q <= '0;
    else if (cnt_q != FULL)  cnt_q <= cnt_q + TW'(1);
  end

  assign abort_o = deferring_i && (cnt_q == LAST);

  a_r9_only_deferring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> deferring_i);
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

// File: rtl/tx_err_stats.sv
module tx_err_stats
  import tx_stats_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned DEFER_LIMIT = 400000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [6:0]       stat_i,
  input  logic             deferring_i,
  output logic             defer_abort_o,
  input  logic             rd_i,
  input  logic             rd_clr_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int unsigned NSLOT = 1 << AW;

  logic [N_CNT-1:0] inc;
  logic [CNT_W-1:0] slot [NSLOT];
  logic [CNT_W-1:0] rd_q;

  assign inc = flag_to_inc(done_i, stat_i);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < N_CNT) begin : g_cnt
      logic clr;
      assign clr = rd_i && rd_clr_i && (rd_addr_i == AW'(i));
      tx_sat_counter #(.W(CNT_W)) i_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (inc[i]),
        .clr_i  (clr),
        .cnt_o  (slot[i])
      );
    end else begin : g_empty
      assign slot[i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (rd_i) rd_q <= slot[rd_addr_i];
  end
  assign rd_data_o = rd_q;

  tx_defer_timer #(.LIMIT(DEFER_LIMIT)) i_defer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .deferring_i (deferring_i),
    .abort_o     (defer_abort_o)
  );

  a_r5_idle_errored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !(rd_i && rd_clr_i)) |=> slot[0] == $past(slot[0]));
  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
endmodule

// File: tb/test_tx_err_stats.sv
`timescale 1ns/1ps
module test_tx_err_stats;
  localparam int unsigned W   = 4;
  localparam int unsigned LIM = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         done = 0;
  logic [6:0]   stat = '0;
  logic         deferring = 0;
  logic         abort;
  logic         rd = 0;
  logic         rd_clr = 0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tx_err_stats #(.CNT_W(W), .DEFER_LIMIT(LIM)) i_tx_err_stats (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .stat_i(stat),
    .deferring_i(deferring), .defer_abort_o(abort),
    .rd_i(rd), .rd_clr_i(rd_clr), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [6:0] f);
    @(negedge clk); done = 1; stat = f;
    @(negedge clk); done = 0; stat = '0;
  endtask

  // read, returning the value seen one cycle later
  task automatic rd_cnt(input int a, input logic clr, output int v);
    @(negedge clk); rd = 1; rd_clr = clr; rd_addr = 3'(a);
    @(negedge clk); rd = 0; rd_clr = 0;
    v = int'(rd_data);
  endtask

  function automatic int exp_cnt(input int a, input logic [6:0] p);
    if (a == 0) return (p & 7'b110_0111) != 0 ? 1 : 0;
    if (a <= 5) return int'(p[a-1]);
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    int v2;
    repeat (3) @(negedge clk);
    #1 chk("R1 abort", int'(abort), 0);
    rst_n = 1;
    for (int a = 0; a < 6; a++) begin
      rd_cnt(a, 0, v); chk("R1 reset", v, 0);
    end

    // R2 R3 R4: all flag patterns, read-clear after each
    for (int p = 0; p < 128; p++) begin
      strobe(7'(p));
      for (int a = 0; a < 6; a++) begin
        rd_cnt(a, 1, v);
        chk($sformatf("R2/R3/R4 pat %0d addr %0d", p, a), v, exp_cnt(a, 7'(p)));
      end
    end

    // R5: flags without strobe
    @(negedge clk); stat = 7'h7f; done = 0;
    @(negedge clk); stat = '0;
    for (int a = 0; a < 6; a++) begin
      rd_cnt(a, 0, v); chk("R5 no strobe", v, 0);
    end

    // R6: saturation
    for (int i = 0; i < 20; i++) strobe(7'b000_0001);
    rd_cnt(1, 0, v); chk("R6 saturate coll", v, 15);
    rd_cnt(0, 0, v); chk("R6 saturate errored", v, 15);

    // R7: plain read keeps value, out-of-range reads zero
    rd_cnt(1, 0, v); rd_cnt(1, 0, v2); chk("R7 read keeps", v2, v);
    rd_cnt(6, 0, v); chk("R7 addr 6", v, 0);
    rd_cnt(7, 0, v); chk("R7 addr 7", v, 0);
    @(negedge clk); chk("R7 data holds", int'(rd_data), 0);

    // R8: clear with coincident increment
    rd_cnt(1, 1, v); chk("R8 pre-clear value", v, 15);
    rd_cnt(1, 0, v); chk("R8 cleared", v, 0);
    for (int i = 0; i < 3; i++) strobe(7'b000_0001);
    @(negedge clk); rd = 1; rd_clr = 1; rd_addr = 3'd1; done = 1; stat = 7'b000_0001;
    @(negedge clk); rd = 0; rd_clr = 0; done = 0; stat = '0;
    chk("R8 read returns old", int'(rd_data), 3);
    rd_cnt(1, 0, v); chk("R8 clear plus inc", v, 1);

    // R9: short run raises nothing
    for (int i = 1; i <= LIM - 1; i++) begin
      @(negedge clk); deferring = 1; #1 chk("R9 short run", int'(abort), 0);
    end
    @(negedge clk); deferring = 0; #1 chk("R9 drop", int'(abort), 0);
    // full run: pulse exactly on cycle LIM
    for (int i = 1; i <= LIM + 3; i++) begin
      @(negedge clk); deferring = 1; #1 chk($sformatf("R9 cycle %0d", i), int'(abort), (i == LIM) ? 1 : 0);
    end
    @(negedge clk); deferring = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule